// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width modulated output with a 10-bit duty resolution. Its time base is an 8-bit timer extended below by a 2-bit sub-count. The sub-count advances once per enabled tick, and the timer advances each time the sub-count wraps. An 8-bit period register marks the end of each cycle. When the timer reaches the period value and the sub-count wraps, a new cycle starts. At that moment the timer returns to zero, the output rises, and the pending duty value is copied into a shadow register. The output falls when the 10-bit time base reaches the shadow value.

Software programs the block through a small write port with three registers. Address 0 holds the period. Address 1 holds the upper eight duty bits. Address 2 is the control register: its bits [1:0] are the two lower duty bits and its bit 2 is the enable. The `tickEn` input gates the time base, so the rate of the waveform follows the rate of ticks. Because the duty value is double-buffered, a duty change written at any time takes effect from the next cycle.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is low, and the control register is cleared, so the output stays low until software sets the enable bit (bit 2 of address 2).
- R2: With the block enabled, one PWM cycle lasts 4*(P+1) ticks, where P is the period register at address 0.
- R3: The output is high for exactly D ticks at the start of each cycle, where D = {address 1 value, address 2 bits [1:0]} and 0 < D < 4*(P+1).
- R4: A duty value of zero keeps the output low for the whole cycle.
- R5: A duty value of 4*(P+1) or more keeps the output high for the whole cycle.
- R6: A duty write in the middle of a cycle does not change that cycle; the new value applies from the next cycle start.
- R7: When the block is enabled, the time base starts at zero and the output stays low for 4*(P+1) ticks; the first cycle start then loads the first duty value.
- R8: Writing the control register with the enable bit clear forces the output low from the next clock edge, and the output stays low while the block is disabled.
- R9: While `tickEn` is low, the time base and the output hold their values; with ticks on every second clock, all high and low times double in clock cycles.
- R10: A write to address 3 has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 period, 1 duty high bits, 2 control |
| wrData | input | 8 | Register write data |
| tickEn | input | 1 | Time base advance enable |
| pwmOut | output | 1 | PWM output |

## Verification
The assertions assume that `tickEn` and the write port are sampled only on the clock edge. They also assume that a control write can change the enable in any cycle, so the frozen-output property leaves out every cycle with such a write and every cycle with the block disabled. The bench drives all inputs on the falling edge. It changes the period only while the block is disabled, so the timer never runs past a freshly lowered period. The only mid-cycle writes it makes are the duty and unused-address writes that R6 and R10 describe.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DUTY_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL    = 2'd2;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic hold;      // block disabled: clear time base and output
    logic advSub;    // advance the sub-count
    logic advTimer;  // advance the 8-bit timer
    logic restart;   // period end: clear timer, load shadow duty
    logic setOut;    // drive output high
    logic clrOut;    // drive output low
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_control.sv
module pwm_control
  import pwm_pkg::*;
(
  input  logic       enable,
  input  logic       tickEn,
  input  logic       subAtMax,
  input  logic       timerAtPeriod,
  input  logic       nextHitsDuty,
  input  logic       pendingNonZero,
  output pwmStrobe_t stb
);
  logic carry;

  always_comb begin
    stb          = '0;
    stb.hold     = !enable;
    stb.advSub   = enable && tickEn;
    carry        = stb.advSub && subAtMax;
    stb.restart  = carry && timerAtPeriod;
    stb.advTimer = carry && !timerAtPeriod;
    stb.setOut   = stb.restart && pendingNonZero;
    stb.clrOut   = stb.hold
                || (stb.restart && !pendingNonZero)
                || (stb.advSub && !stb.restart && nextHitsDuty);
  end
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int SUB_W   = 2,
  parameter int DUTY_W  = TIMER_W + SUB_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [TIMER_W-1:0] wrData,
  input  pwmStrobe_t         stb,
  output logic               enable,
  output logic               subAtMax,
  output logic               timerAtPeriod,
  output logic               nextHitsDuty,
  output logic               pendingNonZero,
  output logic [DUTY_W-1:0]  timeBase,
  output logic [DUTY_W-1:0]  shadowDuty,
  output logic               pwmOut
);
  localparam logic [SUB_W-1:0]   SUB_MAX  = '1;
  localparam logic [DUTY_W-1:0]  TB_ONE   = DUTY_W'(1);
  localparam logic [TIMER_W-1:0] TMR_ONE  = TIMER_W'(1);
  localparam int                 EN_BIT   = SUB_W;

  logic [TIMER_W-1:0] periodQ, dutyHiQ, timerQ;
  logic [SUB_W-1:0]   dutyLoQ, subQ;
  logic [DUTY_W-1:0]  shadowQ, pendingDuty, tbNext;
  logic               enableQ, outQ;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodQ <= '0;
      dutyHiQ <= '0;
      dutyLoQ <= '0;
      enableQ <= 1'b0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_PERIOD:  periodQ <= wrData;
        ADDR_DUTY_HI: dutyHiQ <= wrData;
        ADDR_CTRL: begin
          dutyLoQ <= wrData[SUB_W-1:0];
          enableQ <= wrData[EN_BIT];
        end
        default: ;
      endcase
    end
  end

  // time base and shadow duty
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ  <= '0;
      subQ    <= '0;
      shadowQ <= '0;
    end else if (stb.hold) begin
      timerQ <= '0;
      subQ   <= '0;
    end else begin
      if (stb.advSub)   subQ   <= subQ + 1'b1;
      if (stb.advTimer) timerQ <= timerQ + TMR_ONE;
      if (stb.restart) begin
        timerQ  <= '0;
        shadowQ <= pendingDuty;
      end
    end
  end

  // output latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outQ <= 1'b0;
    else if (stb.clrOut)  outQ <= 1'b0;
    else if (stb.setOut)  outQ <= 1'b1;
  end

  assign pendingDuty    = {dutyHiQ, dutyLoQ};
  assign timeBase       = {timerQ, subQ};
  assign tbNext         = timeBase + TB_ONE;
  assign enable         = enableQ;
  assign subAtMax       = (subQ == SUB_MAX);
  assign timerAtPeriod  = (timerQ == periodQ);
  assign nextHitsDuty   = (tbNext == shadowQ);
  assign pendingNonZero = (pendingDuty != '0);
  assign shadowDuty     = shadowQ;
  assign pwmOut         = outQ;
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int TIMER_W = 8,
  parameter int SUB_W   = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [TIMER_W-1:0] wrData,
  input  logic               tickEn,
  output logic               pwmOut
);
  localparam int DUTY_W = TIMER_W + SUB_W;

  pwmStrobe_t        stb;
  logic              ctrlEnable, subAtMax, timerAtPeriod, nextHitsDuty, pendingNonZero;
  logic [DUTY_W-1:0] timeBase, shadowDuty;

  pwm_control i_ctrl (
    .enable        (ctrlEnable),
    .tickEn        (tickEn),
    .subAtMax      (subAtMax),
    .timerAtPeriod (timerAtPeriod),
    .nextHitsDuty  (nextHitsDuty),
    .pendingNonZero(pendingNonZero),
    .stb           (stb)
  );

  pwm_datapath #(.TIMER_W(TIMER_W), .SUB_W(SUB_W), .DUTY_W(DUTY_W)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .wrAddr        (wrAddr),
    .wrData        (wrData),
    .stb           (stb),
    .enable        (ctrlEnable),
    .subAtMax      (subAtMax),
    .timerAtPeriod (timerAtPeriod),
    .nextHitsDuty  (nextHitsDuty),
    .pendingNonZero(pendingNonZero),
    .timeBase      (timeBase),
    .shadowDuty    (shadowDuty),
    .pwmOut        (pwmOut)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker
  import pwm_pkg::*;
#(
  parameter int DUTY_W = 10
)(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              tickEn,
  input logic              pwmOut,
  input logic              enable,
  input pwmStrobe_t        stb,
  input logic [DUTY_W-1:0] timeBase,
  input logic [DUTY_W-1:0] shadowDuty
);
  logic ctrlWrite;
  assign ctrlWrite = wrEn && (wrAddr == ADDR_CTRL);

  // R2: a cycle start returns the time base to zero
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (timeBase == '0));

  // R6: the shadow duty changes only at a cycle start
  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.restart |=> $stable(shadowDuty));

  // R4: a zero shadow duty never coexists with a high output
  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rstN)
    (shadowDuty == '0) |-> !pwmOut);

  // R8: disabled block drives low on the next edge
  a_r8_off_low: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !pwmOut);

  // R9: no tick, no change
  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && enable && !ctrlWrite) |=> ($stable(pwmOut) && $stable(timeBase)));

  // R7: the output rises only at a cycle start
  a_r7_rise_at_restart: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> $past(stb.restart));
endmodule

bind pwm_gen pwm_checker #(.DUTY_W(DUTY_W)) u_pwm_checker (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .tickEn    (tickEn),
  .pwmOut    (pwmOut),
  .enable    (ctrlEnable),
  .stb       (stb),
  .timeBase  (timeBase),
  .shadowDuty(shadowDuty)
);

// File: tb/test_pwm_gen.sv
module test_pwm_gen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       tickEn = 1'b1;
  logic       pwmOut;

  int  total = 0;
  int  bad = 0;
  int  tickMode = 0;     // 0: always, 1: every other clock, 2: stopped
  bit  monOn = 1'b0;

  typedef struct {
    int    hi;
    int    lo;
    string tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  pwm_gen i_pwm_gen (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .tickEn(tickEn),
    .pwmOut(pwmOut)
  );

  always @(negedge clk) begin
    case (tickMode)
      0:       tickEn = 1'b1;
      1:       tickEn = ~tickEn;
      default: tickEn = 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures high and low runs of each full cycle
  int phase = 0, hiCnt = 0, loCnt = 0;
  bit prevOut = 1'b0;
  always @(negedge clk) begin
    if (!monOn) phase = 0;
    else begin
      if (pwmOut && !prevOut) begin
        if (phase == 2 && q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          chk(hiCnt == e.hi, {e.tag, " high"}, hiCnt, e.hi);
          chk(loCnt == e.lo, {e.tag, " low"}, loCnt, e.lo);
        end
        phase = 1;
        hiCnt = 1;
      end else if (!pwmOut && prevOut && phase == 1) begin
        phase = 2;
        loCnt = 1;
      end else if (pwmOut && phase == 1) hiCnt++;
      else if (!pwmOut && phase == 2) loCnt++;
    end
    prevOut = pwmOut;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfg(input int p, input int d);
    wr(2'd2, 8'h00);
    wr(2'd0, p[7:0]);
    wr(2'd1, d[9:2]);
    wr(2'd2, {5'b0, 1'b1, d[1:0]});
  endtask

  task automatic push(input int n, input int hi, input int lo, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.hi = hi; e.lo = lo; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic drain(input string tag);
    int c = 0;
    while (q.size() > 0 && c < 3000) begin
      @(negedge clk);
      c++;
    end
    chk(q.size() == 0, {tag, " cycles observed"}, q.size(), 0);
    q.delete();
    monOn = 1'b0;
  endtask

  task automatic waitRise();
    bit p = pwmOut;
    int c = 0;
    while (c < 2000) begin
      @(negedge clk);
      c++;
      if (pwmOut && !p) break;
      p = pwmOut;
    end
  endtask

  task automatic countLevel(input bit lvl, output int n);
    n = 0;
    while (pwmOut == lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic countHigh(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut) n++;
    end
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    bit v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and disabled after reset
    chk(pwmOut == 1'b0, "R1 reset output", pwmOut, 0);
    countHigh(60, n);
    chk(n == 0, "R1 stays low while control cleared", n, 0);

    // R7: start from zero, first cycle after 4*(P+1) ticks
    cfg(4, 7);
    countLevel(1'b0, n);
    chk(n == 20, "R7 low before first cycle", n, 20);
    countLevel(1'b1, n);
    chk(n == 7, "R7 first high run", n, 7);

    // R3 / R2: several patterns, duty with low bits
    cfg(9, 23);
    push(3, 23, 17, "R3 P9 D23");
    monOn = 1'b1;
    drain("R3");
    cfg(2, 5);
    push(3, 5, 7, "R2 P2 D5");
    monOn = 1'b1;
    drain("R2");
    cfg(0, 2);
    push(3, 2, 2, "R2 P0 D2");
    monOn = 1'b1;
    drain("R2 short");

    // R6: mid-cycle duty write applies from the next cycle
    cfg(9, 23);
    push(1, 23, 17, "R6 current cycle");
    push(1, 30, 10, "R6 next cycle");
    monOn = 1'b1;
    waitRise();
    wr(2'd1, 8'd7);
    wr(2'd2, 8'h06);
    drain("R6");

    // R10: unused address write ignored
    push(2, 30, 10, "R10");
    monOn = 1'b1;
    wr(2'd3, 8'h00);
    wr(2'd3, 8'hFF);
    drain("R10");

    // R4: zero duty
    cfg(3, 0);
    repeat (20) @(negedge clk);
    countHigh(64, n);
    chk(n == 0, "R4 zero duty high count", n, 0);

    // R5: duty at and above the full cycle
    cfg(3, 1023);
    repeat (20) @(negedge clk);
    countHigh(64, n);
    chk(n == 64, "R5 duty 1023 high count", n, 64);
    cfg(3, 16);
    repeat (20) @(negedge clk);
    countHigh(64, n);
    chk(n == 64, "R5 duty equal to cycle high count", n, 64);

    // R8: disable during high phase
    cfg(9, 23);
    waitRise();
    wr(2'd2, 8'h00);
    @(negedge clk);
    chk(pwmOut == 1'b0, "R8 low after disable", pwmOut, 0);
    countHigh(40, n);
    chk(n == 0, "R8 stays low", n, 0);

    // R9: half-rate ticks double every run
    tickMode = 1;
    cfg(2, 5);
    push(2, 10, 14, "R9 half rate");
    monOn = 1'b1;
    drain("R9");

    // R9: stopped ticks freeze the output
    tickMode = 0;
    cfg(9, 23);
    waitRise();
    tickMode = 2;
    repeat (2) @(negedge clk);
    v = pwmOut;
    chk(v == 1'b1, "R9 frozen while high", v, 1);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwmOut != v) n++;
    end
    chk(n == 0, "R9 output changes with ticks stopped", n, 0);
    tickMode = 0;
    countLevel(1'b1, n);
    chk(pwmOut == 1'b0, "R9 resumes and falls", pwmOut, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule